// File: doc/BRIEF.md
# SPI Status Flag Unit

This block keeps the three status flags of a serial peripheral interface that can move 8 or 16 bits per transfer, and runs the bus-side access sequences that clear them. The receive-done flag rises when a received word lands in the data register. The mode-fault flag rises when the slave-select line falls while the peripheral is a master and fault detection is switched on. The transmit-empty flag follows the state of the transmit data register.

A flag is never cleared by a single access. A status register read that sees the flag set arms that flag's clear sequence. The arming is stored per flag at the time of the read. A later low-byte or word read of the data register then clears the receive-done flag. A later write to control register 1 clears the mode-fault flag. Writes to the status register change nothing. Each flag also drives an interrupt request, gated by its own enable input.

Top module: `spi_status_flags`

## Requirements
- R1: After reset the status byte reads 0x20 (transmit-empty set, all other bits clear) and all three interrupt requests are low.
- R2: Bits 6, 3, 2, 1 and 0 of the status byte always read 0. A status register write never changes bits 7 or 4.
- R3: A receive-done pulse sets status bit 7 on the clock edge that samples it.
- R4: A status read that sees bit 7 set, followed later by a low-byte read or a word read of the data register, clears bit 7 on the edge that samples that data read.
- R5: High-byte data reads never clear bit 7, however often they repeat. An armed high-byte read followed by a low-byte read still clears it.
- R6: A data read clears nothing unless an earlier status read saw bit 7 set. A status read made while bit 7 was clear does not arm the clear.
- R7: Status bit 4 sets one edge after the slave-select input goes from high to low, but only while both master mode and fault detection are enabled.
- R8: A status read that sees bit 4 set, followed by a control register 1 write, clears bit 4. A control write with no such status read leaves it set.
- R9: Status bit 5 equals the transmit-empty input as sampled on the previous clock edge.
- R10: When a flag's set event and its armed clearing access fall in the same cycle, the flag stays set and the arming is used up. A new status read is then needed to clear it.
- R11: Each interrupt request is high exactly when its flag is set and its enable input is high: receive-done with bit 7, transmit-empty with bit 5, mode fault with bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_done_i | input | 1 | Received data moved into the data register (one-cycle pulse) |
| tx_empty_i | input | 1 | Transmit data register is empty |
| ss_n_i | input | 1 | Slave-select input level, low active |
| master_i | input | 1 | Peripheral is configured as master |
| fault_en_i | input | 1 | Mode-fault detection enabled |
| stat_rd_i | input | 1 | Bus read of the status register |
| stat_wr_i | input | 1 | Bus write to the status register |
| data_hi_rd_i | input | 1 | Byte read of the high data half |
| data_lo_rd_i | input | 1 | Byte read of the low data half |
| data_word_rd_i | input | 1 | Word read of both data halves |
| ctrl1_wr_i | input | 1 | Bus write to control register 1 |
| rx_ie_i | input | 1 | Receive-done interrupt enable |
| tx_ie_i | input | 1 | Transmit-empty interrupt enable |
| fault_ie_i | input | 1 | Mode-fault interrupt enable |
| status_o | output | 8 | Status byte: bit 7 receive-done, bit 5 transmit-empty, bit 4 mode fault |
| rx_irq_o | output | 1 | Receive-done interrupt request |
| tx_irq_o | output | 1 | Transmit-empty interrupt request |
| fault_irq_o | output | 1 | Mode-fault interrupt request |

## Verification
The assertions assume a bus that makes at most one register access per cycle. A status read therefore never shares a cycle with a data read or a control write. The clear-source checks rely on this when they tie a falling flag to the access of the previous cycle. The stimulus issues every access as a single-cycle strobe with an idle cycle after it. Receive-done pulses and slave-select edges are kept away from unrelated accesses, except in the one sequence that deliberately collides a set event with its armed clearing read.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;

    localparam int STAT_W  = 8;
    localparam int RX_BIT  = 7;
    localparam int TX_BIT  = 5;
    localparam int FLT_BIT = 4;

    // Per-flag state: the flag itself and its armed clear sequence
    typedef struct packed {
        logic flag;
        logic armed;
    } seq_flag_t;

    typedef struct packed {
        logic ss_prev;
    } edge_state_t;

    typedef struct packed {
        logic tx_empty;
    } top_state_t;

endpackage

// File: rtl/spi_seq_flag.sv
module spi_seq_flag
    import spi_stat_pkg::*;
#(
    parameter logic RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic arm_rd_i,
    input  logic clr_acc_i,
    output logic flag_o
);

    seq_flag_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // status read records whether it saw the flag set
        if (arm_rd_i) begin
            st_d.armed = st_q.flag;
        end
        // armed clearing access consumes the arming
        if (clr_acc_i && st_q.armed) begin
            st_d.flag  = 1'b0;
            st_d.armed = 1'b0;
        end
        // a set event always wins
        if (set_i) begin
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{flag: RESET_VAL, armed: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;

    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> st_q.flag);

    assert_clear_needs_arm_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.flag) |-> $past(st_q.armed && clr_acc_i));

    assert_arm_implies_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.armed |-> st_q.flag);

endmodule

// File: rtl/spi_fault_detect.sv
module spi_fault_detect
    import spi_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ss_n_i,
    input  logic master_i,
    input  logic en_i,
    output logic fault_evt_o
);

    edge_state_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.ss_prev = ss_n_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ss_prev: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    // high-to-low transition of slave select while master with detection on
    assign fault_evt_o = st_q.ss_prev && !ss_n_i && master_i && en_i;

endmodule

// File: rtl/spi_status_flags.sv
module spi_status_flags
    import spi_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_done_i,
    input  logic              tx_empty_i,
    input  logic              ss_n_i,
    input  logic              master_i,
    input  logic              fault_en_i,
    input  logic              stat_rd_i,
    input  logic              stat_wr_i,
    input  logic              data_hi_rd_i,
    input  logic              data_lo_rd_i,
    input  logic              data_word_rd_i,
    input  logic              ctrl1_wr_i,
    input  logic              rx_ie_i,
    input  logic              tx_ie_i,
    input  logic              fault_ie_i,
    output logic [STAT_W-1:0] status_o,
    output logic              rx_irq_o,
    output logic              tx_irq_o,
    output logic              fault_irq_o
);

    logic rx_flag, fault_flag, fault_evt, lo_access;
    top_state_t st_d, st_q;

    // low half is read by a byte read or as part of a word read;
    // a high-byte read alone is not a clearing access
    assign lo_access = data_lo_rd_i || data_word_rd_i;

    spi_seq_flag #(.RESET_VAL(1'b0)) u_rx_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (rx_done_i),
        .arm_rd_i  (stat_rd_i),
        .clr_acc_i (lo_access),
        .flag_o    (rx_flag)
    );

    spi_fault_detect u_fault_det (
        .clk         (clk),
        .rst_n       (rst_n),
        .ss_n_i      (ss_n_i),
        .master_i    (master_i),
        .en_i        (fault_en_i),
        .fault_evt_o (fault_evt)
    );

    spi_seq_flag #(.RESET_VAL(1'b0)) u_fault_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (fault_evt),
        .arm_rd_i  (stat_rd_i),
        .clr_acc_i (ctrl1_wr_i),
        .flag_o    (fault_flag)
    );

    always_comb begin
        st_d          = st_q;
        st_d.tx_empty = tx_empty_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{tx_empty: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        status_o          = '0;
        status_o[RX_BIT]  = rx_flag;
        status_o[TX_BIT]  = st_q.tx_empty;
        status_o[FLT_BIT] = fault_flag;
    end

    assign rx_irq_o    = rx_flag && rx_ie_i;
    assign tx_irq_o    = st_q.tx_empty && tx_ie_i;
    assign fault_irq_o = fault_flag && fault_ie_i;

    assert_rx_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done_i |=> status_o[RX_BIT]);

    assert_rx_clear_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status_o[RX_BIT]) |-> $past(lo_access));

    assert_fault_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fault_evt |=> status_o[FLT_BIT]);

    assert_fault_clear_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status_o[FLT_BIT]) |-> $past(ctrl1_wr_i));

    assert_tx_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> status_o[TX_BIT] == $past(tx_empty_i));

    assert_stat_wr_inert_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr_i && !rx_done_i && !fault_evt && !lo_access && !ctrl1_wr_i)
        |=> $stable(status_o[RX_BIT]) && $stable(status_o[FLT_BIT]));

endmodule

// File: tb/tb_spi_status_flags.sv
`timescale 1ns/1ps
module tb_spi_status_flags;

    localparam int A_STAT = 1, A_HI = 2, A_LO = 3, A_WORD = 4,
                   A_CTRL = 5, A_SWR = 6, A_RX = 7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_done = 0, tx_empty = 1, ss_n = 1, master = 0, fault_en = 0;
    logic       stat_rd = 0, stat_wr = 0, hi_rd = 0, lo_rd = 0, word_rd = 0, ctrl_wr = 0;
    logic       rx_ie = 0, tx_ie = 0, fault_ie = 0;
    logic [7:0] status;
    logic       rx_irq, tx_irq, fault_irq;
    int         checks = 0, failures = 0;

    always #2.5 clk = ~clk;

    spi_status_flags dut (
        .clk(clk), .rst_n(rst_n), .rx_done_i(rx_done), .tx_empty_i(tx_empty),
        .ss_n_i(ss_n), .master_i(master), .fault_en_i(fault_en),
        .stat_rd_i(stat_rd), .stat_wr_i(stat_wr), .data_hi_rd_i(hi_rd),
        .data_lo_rd_i(lo_rd), .data_word_rd_i(word_rd), .ctrl1_wr_i(ctrl_wr),
        .rx_ie_i(rx_ie), .tx_ie_i(tx_ie), .fault_ie_i(fault_ie),
        .status_o(status), .rx_irq_o(rx_irq), .tx_irq_o(tx_irq), .fault_irq_o(fault_irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic set_strobe(input int kind, input logic v);
        case (kind)
            A_STAT: stat_rd = v;
            A_HI:   hi_rd   = v;
            A_LO:   lo_rd   = v;
            A_WORD: word_rd = v;
            A_CTRL: ctrl_wr = v;
            A_SWR:  stat_wr = v;
            A_RX:   rx_done = v;
            default: ;
        endcase
    endtask

    // one-cycle strobe; returns at the negedge after the capturing edge
    task automatic access(input int kind);
        @(negedge clk);
        set_strobe(kind, 1'b1);
        @(negedge clk);
        set_strobe(kind, 1'b0);
    endtask

    function automatic int rsv(input logic [7:0] s);
        return int'(s & 8'h4F);
    endfunction

    initial begin
        #1_000_000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 status", int'(status), 8'h20);
        chk("R1 irqs", int'({rx_irq, tx_irq, fault_irq}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", int'(status), 8'h20);

        // R3/R4/R5: sweep over clearing read kinds (0 lo, 1 word, 2 hi repeats then lo)
        for (int k = 0; k < 3; k++) begin
            access(A_RX);
            chk("R3 rx set", int'(status[7]), 1);
            chk("R2 reserved zero", rsv(status), 0);
            access(A_STAT);
            if (k == 2) begin
                for (int n = 0; n < 3; n++) begin
                    access(A_HI);
                    chk("R5 hi read keeps flag", int'(status[7]), 1);
                end
            end
            access(k == 1 ? A_WORD : A_LO);
            chk("R4 R5 armed low read clears", int'(status[7]), 0);
            chk("R2 reserved zero", rsv(status), 0);
        end

        // R6: unarmed data reads, and a status read made before the flag set
        access(A_STAT);
        access(A_RX);
        access(A_LO);
        chk("R6 stale arm no clear", int'(status[7]), 1);
        access(A_WORD);
        chk("R6 unarmed word read", int'(status[7]), 1);
        // R2: status write does not touch the flag
        access(A_SWR);
        chk("R2 status write inert", int'(status[7]), 1);
        access(A_STAT);
        access(A_SWR);
        chk("R2 status write inert armed", int'(status[7]), 1);
        access(A_LO);
        chk("R6 armed clear", int'(status[7]), 0);

        // R10: set event collides with armed clearing read
        access(A_RX);
        access(A_STAT);
        @(negedge clk);
        rx_done = 1; lo_rd = 1;
        @(negedge clk);
        rx_done = 0; lo_rd = 0;
        chk("R10 set wins", int'(status[7]), 1);
        access(A_LO);
        chk("R10 arm consumed", int'(status[7]), 1);
        access(A_STAT);
        access(A_LO);
        chk("R10 rearm clears", int'(status[7]), 0);

        // R7/R8: sweep master and detection enable
        for (int m = 0; m < 2; m++) begin
            for (int e = 0; e < 2; e++) begin
                @(negedge clk);
                master = logic'(m); fault_en = logic'(e);
                ss_n = 0;
                @(negedge clk);
                chk("R7 fault on ss fall", int'(status[4]), m & e);
                @(negedge clk);
                chk("R7 no retrigger while low", int'(status[4]), m & e);
                ss_n = 1;
                access(A_CTRL);
                chk("R8 unarmed ctrl write", int'(status[4]), m & e);
                access(A_STAT);
                access(A_CTRL);
                chk("R8 armed ctrl write clears", int'(status[4]), 0);
                chk("R2 reserved zero", rsv(status), 0);
            end
        end

        // R9: transmit-empty follows input with one register
        for (int v = 0; v < 4; v++) begin
            @(negedge clk);
            tx_empty = logic'(v & 1);
            @(negedge clk);
            chk("R9 tx follows", int'(status[5]), v & 1);
        end
        tx_empty = 1;

        // R11: all enable combinations with all flags set, then with flags clear
        access(A_RX);
        @(negedge clk); ss_n = 0;
        @(negedge clk); ss_n = 1;
        @(negedge clk);
        for (int ie = 0; ie < 8; ie++) begin
            rx_ie = logic'(ie[2]); tx_ie = logic'(ie[1]); fault_ie = logic'(ie[0]);
            #1;
            chk("R11 irq flags set", int'({rx_irq, tx_irq, fault_irq}), ie);
        end
        access(A_STAT);
        access(A_LO);
        access(A_STAT);
        access(A_CTRL);
        tx_empty = 0;
        @(negedge clk);
        chk("R11 flags cleared", int'(status), 0);
        for (int ie = 0; ie < 8; ie++) begin
            rx_ie = logic'(ie[2]); tx_ie = logic'(ie[1]); fault_ie = logic'(ie[0]);
            #1;
            chk("R11 irq flags clear", int'({rx_irq, tx_irq, fault_irq}), 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule